// File: doc/BRIEF.md
# Per-Processor Interrupt Mask Controller

This block gathers up to 22 level-sensitive interrupt requests for one processor and produces a single interrupt line. A raw status vector holds the current level of every request. An enable register is applied to it to form the masked status, and the interrupt line is raised while any masked bit is set. Bit 0 of the vector is not wired to a pin. It is a software interrupt that firmware raises and drops through two dedicated write locations.

Software reaches the block through a small word-addressed register port. It uses one strobe for writes and one for reads, and read data is returned one cycle later. The enable register never needs a read-modify-write. Software writes ones to one location to turn bits on, and ones to another location to turn bits off. Zero bits in either write leave the register untouched, so several drivers sharing the processor can each manage their own bits without racing one another.

A build-time mask says which of the external request pins are really connected. Raw bits without a connection always read as zero.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Reading byte offset 0x4 returns the raw status. Bit 0 is the software interrupt flag. Every bit set in SRC_PRESENT follows the matching `src_i` bit. Input `src_i[0]` is never used.
- R2: Reading offset 0x0 returns the raw status ANDed bitwise with the enable register.
- R3: A write to offset 0x8 sets every enable bit whose write-data bit is 1 and leaves the others unchanged. A read of 0x8 returns the enable register.
- R4: A write to offset 0xC clears every enable bit whose write-data bit is 1 and leaves the others unchanged.
- R5: After reset the enable register is all zeros and `irq_o` is low.
- R6: `irq_o` is a register. After each clock edge it holds the OR of all masked status bits as they stood just before that edge.
- R7: A write to offset 0x10 with data bit 0 at 1 sets the software flag. A write to offset 0x14 with data bit 0 at 1 clears it. A write to either location with data bit 0 at 0 has no effect.
- R8: Reads return zero at the write-only offsets 0xC, 0x10 and 0x14, at unmapped offsets (0x18 and above), and at any address whose two low bits are not zero. Read-data bits 22 to 31 are always zero, and write-data bits 22 to 31 are ignored.
- R9: `bus_rdata_o` is loaded on the clock edge where `bus_rd_i` is high, and holds its value otherwise. The value loaded shows the state from before any write taken on that same edge.
- R10: Writes to offsets 0x0, 0x4, 0x18 and 0x1C change neither the enable register nor the software flag.
- R11: Raw bits that are clear in SRC_PRESENT, other than bit 0, read as zero whatever `src_i` drives. With the default SRC_PRESENT of 0x3FFFE0, these are bits 1 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Level-sensitive interrupt request inputs |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two events can meet on one clock edge: an external request rising, and an enable-clear write that disables the same bit. The bench drives both on the same edge. It then requires `irq_o` to show one high cycle, because the old enable is still in force, and to be low from the next edge onward. A second meeting is a read and a write to the enable-set location in the same cycle. Here the returned data must show the enable register from before the write, and a later read must show it after the write. The remaining stimulus sweeps a single set bit across every source, every enable-set bit and every enable-clear bit, followed by a series of pseudo-random mask and source patterns. Each result is compared with a bench model of the raw, enable and masked vectors.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned IRQC_NUM_SRC = 22;
  localparam int unsigned IRQC_DATA_W  = 32;
  localparam int unsigned IRQC_ADDR_W  = 5;
  localparam int unsigned SWINT_BIT    = 0;
  localparam int unsigned SLOT_COUNT   = 6;

  // Word slots; the index equals byte offset / 4.
  typedef enum logic [2:0] {
    SLOT_MSTAT = 3'd0,
    SLOT_RAW   = 3'd1,
    SLOT_ENSET = 3'd2,
    SLOT_ENCLR = 3'd3,
    SLOT_SWSET = 3'd4,
    SLOT_SWCLR = 3'd5
  } irqc_slot_e;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
  } irqc_wstrb_t;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = IRQC_ADDR_W
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output irqc_wstrb_t       wstrb_o,
  output irqc_slot_e        slot_o,
  output logic              hit_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  always_comb begin
    word_idx = addr_i[ADDR_W-1:2];
    aligned  = (addr_i[1:0] == 2'b00);
    hit_o    = aligned && (word_idx < IDX_W'(SLOT_COUNT));
    slot_o   = hit_o ? irqc_slot_e'(word_idx[2:0]) : SLOT_MSTAT;

    wstrb_o        = '0;
    wstrb_o.en_set = wr_i && hit_o && (slot_o == SLOT_ENSET);
    wstrb_o.en_clr = wr_i && hit_o && (slot_o == SLOT_ENCLR);
    wstrb_o.sw_set = wr_i && hit_o && (slot_o == SLOT_SWSET);
    wstrb_o.sw_clr = wr_i && hit_o && (slot_o == SLOT_SWCLR);
  end

endmodule

// File: rtl/irqc_enable.sv
module irqc_enable #(
  parameter int unsigned NUM_SRC = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] en_o
);

  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;
  logic [NUM_SRC-1:0] set_bits;
  logic [NUM_SRC-1:0] clr_bits;
  logic               en_load;

  always_comb begin
    set_bits = set_i ? bits_i : '0;
    clr_bits = clr_i ? bits_i : '0;
    en_load  = set_i | clr_i;
    en_d     = (en_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (en_load) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/irqc_swint.sv
module irqc_swint (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic bit_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_load;

  always_comb begin
    flag_load = (set_i | clr_i) & bit_i;
    flag_d    = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_load) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irqc_rdport.sv
module irqc_rdport
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQC_NUM_SRC,
  parameter int unsigned DATA_W  = IRQC_DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               hit_i,
  input  irqc_slot_e         slot_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] masked_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] sel_bits;
  logic [DATA_W-1:0]  rdata_d;
  logic [DATA_W-1:0]  rdata_q;

  always_comb begin
    sel_bits = '0;
    if (hit_i) begin
      unique case (slot_i)
        SLOT_MSTAT: sel_bits = masked_i;
        SLOT_RAW:   sel_bits = raw_i;
        SLOT_ENSET: sel_bits = en_i;
        default:    sel_bits = '0;
      endcase
    end
    rdata_d = {{PAD_W{1'b0}}, sel_bits};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned          NUM_SRC     = IRQC_NUM_SRC,
  parameter int unsigned          ADDR_W      = IRQC_ADDR_W,
  parameter int unsigned          DATA_W      = IRQC_DATA_W,
  parameter logic [NUM_SRC-1:0]   SRC_PRESENT = 22'h3FFFE0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);

  localparam logic [NUM_SRC-1:0] SW_ONEHOT = NUM_SRC'(1) << SWINT_BIT;
  localparam logic [NUM_SRC-1:0] EXT_MASK  = SRC_PRESENT & ~SW_ONEHOT;

  logic               rst_n_sync;
  irqc_wstrb_t        wstrb;
  irqc_slot_e         rd_slot;
  logic               addr_hit;
  logic [NUM_SRC-1:0] en_vec;
  logic               sw_flag;
  logic [NUM_SRC-1:0] sw_vec;
  logic [NUM_SRC-1:0] raw_vec;
  logic [NUM_SRC-1:0] masked_vec;
  logic               irq_d;
  logic               irq_q;

  irqc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wstrb_o (wstrb),
    .slot_o  (rd_slot),
    .hit_o   (addr_hit)
  );

  irqc_enable #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .set_i  (wstrb.en_set),
    .clr_i  (wstrb.en_clr),
    .bits_i (bus_wdata_i[NUM_SRC-1:0]),
    .en_o   (en_vec)
  );

  irqc_swint u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .set_i  (wstrb.sw_set),
    .clr_i  (wstrb.sw_clr),
    .bit_i  (bus_wdata_i[0]),
    .flag_o (sw_flag)
  );

  // Raw vector: software flag at its slot, external pins where present.
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_sw
    if (gi == SWINT_BIT) begin : g_flag
      assign sw_vec[gi] = sw_flag;
    end else begin : g_zero
      assign sw_vec[gi] = 1'b0;
    end
  end

  always_comb begin
    raw_vec    = (src_i & EXT_MASK) | sw_vec;
    masked_vec = raw_vec & en_vec;
    irq_d      = |masked_vec;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  irqc_rdport #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .rd_i     (bus_rd_i),
    .hit_i    (addr_hit),
    .slot_i   (rd_slot),
    .raw_i    (raw_vec),
    .masked_i (masked_vec),
    .en_i     (en_vec),
    .rdata_o  (bus_rdata_o)
  );

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int unsigned NUM_SRC = 22,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_n_sync,
  input logic               bus_wr_i,
  input logic               bus_rd_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic [NUM_SRC-1:0] en_vec,
  input logic               sw_flag,
  input logic [NUM_SRC-1:0] raw_vec,
  input logic               irq_o
);

  logic [ADDR_W-3:0] widx;
  logic              al;
  logic              wr_set, wr_clr, wr_sws, wr_swc, rd_wo;

  always_comb begin
    widx   = bus_addr_i[ADDR_W-1:2];
    al     = (bus_addr_i[1:0] == 2'b00);
    wr_set = bus_wr_i && al && (widx == 2);
    wr_clr = bus_wr_i && al && (widx == 3);
    wr_sws = bus_wr_i && al && (widx == 4);
    wr_swc = bus_wr_i && al && (widx == 5);
    rd_wo  = bus_rd_i && (!al || (widx >= 3));
  end

  p_en_zero_after_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_n_sync) |-> (en_vec == '0));

  p_set_adds_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    wr_set |=> (en_vec == ($past(en_vec) | $past(bus_wdata_i[NUM_SRC-1:0]))));

  p_clr_drops_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    wr_clr |=> (en_vec == ($past(en_vec) & ~$past(bus_wdata_i[NUM_SRC-1:0]))));

  p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !(wr_set || wr_clr) |=> $stable(en_vec));

  p_irq_tracks_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    1'b1 |=> (irq_o == $past(|(raw_vec & en_vec))));

  p_sw_set_r7: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (wr_sws && bus_wdata_i[0]) |=> sw_flag);

  p_sw_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (wr_swc && bus_wdata_i[0]) |=> !sw_flag);

  p_wo_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    rd_wo |=> (bus_rdata_o == '0));

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_n_sync  (rst_n_sync),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .en_vec      (en_vec),
  .sw_flag     (sw_flag),
  .raw_vec     (raw_vec),
  .irq_o       (irq_o)
);

// File: tb/irq_mask_ctrl_test.sv
module irq_mask_ctrl_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          N  = 22;
  localparam int          AW = 5;
  localparam int          DW = 32;
  localparam logic [N-1:0] PRESENT = 22'h3FFFE0;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [N-1:0] m_en;
  logic         m_sw;

  irq_mask_ctrl #(
    .NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW), .SRC_PRESENT(PRESENT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] raw_exp();
    return (src & PRESENT & ~22'h1) | {{(N-1){1'b0}}, m_sw};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
    case (a)
      5'h08: m_en = m_en | d[N-1:0];
      5'h0C: m_en = m_en & ~d[N-1:0];
      5'h10: if (d[0]) m_sw = 1'b1;
      5'h14: if (d[0]) m_sw = 1'b0;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(posedge clk);
    #1 rd = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic chk_irq(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req, {31'b0, irq}, {31'b0, |(raw_exp() & m_en)});
  endtask

  task automatic set_src(input logic [N-1:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [31:0]   lf;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; src = '0;
    m_en = '0; m_sw = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: reset state
    bus_rd(5'h08, d); check("R5 enable after reset", d, '0);
    bus_rd(5'h00, d); check("R5 masked after reset", d, '0);
    check("R5 irq after reset", {31'b0, irq}, '0);

    // R1 / R11: walk one source bit
    for (int i = 0; i < N; i++) begin
      set_src(N'(1) << i);
      bus_rd(5'h04, d);
      if (i >= 1 && i <= 4) check("R11 unconnected raw bit", d, {10'b0, raw_exp()});
      else check("R1 raw follows source", d, {10'b0, raw_exp()});
      bus_rd(5'h00, d); check("R2 masked with empty enable", d, '0);
    end

    // R3 / R2 / R6: walk enable set with all sources high
    set_src('1);
    for (int i = 0; i < N; i++) begin
      bus_wr(5'h08, 32'h1 << i);
      chk_irq("R6 irq after enable set");
      bus_rd(5'h08, d); check("R3 enable readback", d, {10'b0, m_en});
      bus_rd(5'h00, d); check("R2 masked status", d, {10'b0, raw_exp() & m_en});
    end

    // R4: walk enable clear
    for (int i = 0; i < N; i++) begin
      bus_wr(5'h0C, 32'h1 << i);
      bus_rd(5'h08, d); check("R4 enable after clear", d, {10'b0, m_en});
      chk_irq("R6 irq after enable clear");
    end

    // R8: wide write, write-only and unmapped reads
    bus_wr(5'h08, 32'hFFFF_FFFF);
    bus_rd(5'h08, d); check("R8 upper write bits ignored", d, 32'h003F_FFFF);
    bus_rd(5'h0C, d); check("R8 read enable-clear", d, '0);
    bus_rd(5'h10, d); check("R8 read sw-set", d, '0);
    bus_rd(5'h14, d); check("R8 read sw-clear", d, '0);
    bus_rd(5'h18, d); check("R8 read unmapped 0x18", d, '0);
    bus_rd(5'h1C, d); check("R8 read unmapped 0x1C", d, '0);
    bus_rd(5'h09, d); check("R8 read misaligned", d, '0);

    // R10: writes to read-only / unmapped offsets
    bus_wr(5'h0C, 32'h0000_FF00);
    bus_wr(5'h00, 32'hFFFF_FFFF);
    bus_wr(5'h04, 32'hFFFF_FFFF);
    bus_wr(5'h18, 32'hFFFF_FFFF);
    bus_wr(5'h1C, 32'hFFFF_FFFF);
    bus_rd(5'h08, d); check("R10 enable untouched", d, {10'b0, m_en});
    bus_rd(5'h04, d); check("R10 raw untouched", d, {10'b0, raw_exp()});
    bus_wr(5'h0C, 32'hFFFF_FFFF);

    // R7: software interrupt
    set_src('0);
    bus_wr(5'h10, 32'h1);
    bus_rd(5'h04, d); check("R7 sw flag set", d, 32'h1);
    chk_irq("R7 sw flag masked off");
    bus_wr(5'h08, 32'h1);
    chk_irq("R7 sw flag raises irq");
    check("R7 irq high", {31'b0, irq}, 32'h1);
    bus_wr(5'h10, 32'h0);
    bus_wr(5'h14, 32'hFFFF_FFFE);
    bus_rd(5'h04, d); check("R7 zero bit 0 no effect", d, 32'h1);
    bus_wr(5'h14, 32'h1);
    bus_rd(5'h04, d); check("R7 sw flag cleared", d, 32'h0);
    chk_irq("R7 irq drops");
    bus_wr(5'h0C, 32'hFFFF_FFFF);

    // R9: read and write same cycle
    bus_wr(5'h08, 32'h20);
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; addr = 5'h08; wdata = 32'h40;
    @(posedge clk);
    #1 begin wr = 1'b0; rd = 1'b0; end
    m_en = m_en | 22'h40;
    @(negedge clk);
    check("R9 read sees pre-write enable", rdata, 32'h20);
    repeat (2) @(negedge clk);
    check("R9 rdata held", rdata, 32'h20);
    bus_rd(5'h08, d); check("R9 later read sees write", d, 32'h60);

    // R6: source rise coincides with enable clear of same bit
    bus_wr(5'h0C, 32'hFFFF_FFFF);
    bus_wr(5'h08, 32'h20);
    chk_irq("R6 idle before coincidence");
    @(negedge clk);
    src = 22'h20; wr = 1'b1; addr = 5'h0C; wdata = 32'h20;
    @(posedge clk);
    #1 wr = 1'b0;
    @(negedge clk);
    check("R6 coincident edge uses old enable", {31'b0, irq}, 32'h1);
    m_en = m_en & ~22'h20;
    chk_irq("R6 irq low after coincident clear");

    // R2 / R1 / R6: pseudo-random patterns
    lf = 32'h1234_5679;
    for (int k = 0; k < 40; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      set_src(lf[N-1:0]);
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      bus_wr(5'h08, lf);
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      bus_wr(5'h0C, lf & 32'h0F0F_0F0F);
      chk_irq("R6 irq random pattern");
      bus_rd(5'h00, d); check("R2 masked random pattern", d, {10'b0, raw_exp() & m_en});
      bus_rd(5'h04, d); check("R1 raw random pattern", d, {10'b0, raw_exp()});
    end

    summary();
    $finish;
  end

endmodule